// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps time of day and calendar date as packed BCD registers. A synchronous tick enable, pulsed once per hundredth of a second by an external prescaler, advances the hundredths field. A carry then ripples through seconds, minutes, hours, day of week, date, month and a two-digit year, all within the same clock cycle. The hours register holds its own 12/24-hour mode select, and the date wraps at the real length of each month. February has 29 days in every year whose two-digit value is divisible by four.

Software sets the time by presenting all eight registers at once on a parallel load bus. The current state is always visible on a parallel snapshot bus with the same byte layout. A halt bit kept in the day-of-week register freezes counting without losing the time.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Synchronous active-low reset sets hundredths, seconds, minutes and hours to 00 in 24-hour mode, day of week, date and month to 01, year to 00, and clears the halt bit. The snapshot reads 64'h0001010100000000.
- R2: Each accepted tick advances hundredths 00..99. Its wrap advances seconds 00..59, whose wrap advances minutes 00..59, whose wrap advances hours. The whole carry chain settles in the cycle after the tick.
- R3: While bit 5 of register 4 (the halt bit) is 1, ticks are ignored and the snapshot stays unchanged.
- R4: A load writes all eight registers and takes priority over a tick in the same cycle. Bits that are always zero read back as 0. The per-register keep masks, from register 0 to 7, are FF, 7F, 7F, BF, 27, 3F, 1F, FF.
- R5: With bit 7 of register 3 at 0 (24-hour mode), hours run 00..23 in bits 5:0. The wrap from 23 to 00 advances the day.
- R6: With bit 7 of register 3 at 1 (12-hour mode), bit 5 is the PM flag (1 = PM), bit 4 is the tens digit and bits 3:0 the ones digit. Hours run 12, 01, ..., 11, 12. PM toggles on 11 to 12, and the day advances only on 11 PM to 12 AM.
- R7: Date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R8: In month 02 the date wraps after 29 when the year is divisible by four (00 included), and after 28 otherwise.
- R9: Day of week (register 4, bits 2:0) runs 1..7 and wraps to 1. It advances on the same tick as the date.
- R10: The month wraps from 12 to 01 and advances the year, and the year wraps from 99 to 00.
- R11: Snapshot byte i (bits 8i+7..8i) is register i: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day of week and halt, 5 date, 6 month, 7 year. The load bus uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en_i | input | 1 | One-cycle hundredths-of-a-second advance pulse |
| load_en_i | input | 1 | Write all registers from load_data_i |
| load_data_i | input | 64 | New register values, byte i to register i |
| snapshot_o | output | 64 | Current register values, byte i from register i |

## Verification
Two functions can meet in one cycle. A load can arrive together with a tick, and a single tick can carry through every field up to the year. The bench provokes the first by asserting load and tick together, both in a directed case and at random. It expects exactly the masked load value and no advance. It provokes the second by loading times one hundredth before midnight at month and year ends, in both hour modes. The whole snapshot after one tick is judged against a reference model written in integer arithmetic.

// File: rtl/rtc_cal_pkg.sv
// Shared constants, register indices and BCD helpers for the calendar clock.
// Assumes two BCD digits per register byte.
package rtc_cal_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 8;
    localparam int SNAP_W   = BYTE_W * NUM_REGS;

    typedef logic [BYTE_W-1:0] bcd_byte_t;

    localparam int REG_HUND = 0;
    localparam int REG_SEC  = 1;
    localparam int REG_MIN  = 2;
    localparam int REG_HOUR = 3;
    localparam int REG_DOW  = 4;
    localparam int REG_DATE = 5;
    localparam int REG_MON  = 6;
    localparam int REG_YEAR = 7;

    localparam int HR_MODE_BIT  = 7;
    localparam int HR_PM_BIT    = 5;
    localparam int DAY_HALT_BIT = 5;

    // Next BCD value, ones digit rolling from 9 into the tens digit.
    function automatic bcd_byte_t bcd_next(input bcd_byte_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return v + bcd_byte_t'(1);
    endfunction

    // Lowest value a simple field wraps to.
    function automatic bcd_byte_t field_min(input int idx);
        if (idx == REG_DOW || idx == REG_DATE || idx == REG_MON) return 8'h01;
        else                                                    return 8'h00;
    endfunction

    // Highest value of a simple field.
    function automatic bcd_byte_t field_max(input int idx);
        case (idx)
            REG_SEC, REG_MIN: return 8'h59;
            REG_DOW:          return 8'h07;
            REG_MON:          return 8'h12;
            default:          return 8'h99;
        endcase
    endfunction

    // Bits kept by a load; the rest always read zero.
    function automatic bcd_byte_t field_mask(input int idx);
        case (idx)
            REG_SEC, REG_MIN: return 8'h7F;
            REG_HOUR:         return 8'hBF;
            REG_DOW:          return 8'h07;
            REG_DATE:         return 8'h3F;
            REG_MON:          return 8'h1F;
            default:          return 8'hFF;
        endcase
    endfunction

    // Fields whose at-limit state must all hold for field idx to advance.
    function automatic logic [NUM_REGS-1:0] carry_deps(input int idx);
        case (idx)
            REG_HUND:         return 8'h00;
            REG_SEC:          return 8'h01;
            REG_MIN:          return 8'h03;
            REG_HOUR:         return 8'h07;
            REG_DOW, REG_DATE: return 8'h0F;
            REG_MON:          return 8'h2F;
            default:          return 8'h6F;
        endcase
    endfunction

    // Whole-bus load mask, including the halt bit of the day register.
    function automatic logic [SNAP_W-1:0] bus_mask();
        logic [SNAP_W-1:0] m;
        for (int i = 0; i < NUM_REGS; i++) m[i*BYTE_W +: BYTE_W] = field_mask(i);
        m[REG_DOW*BYTE_W + DAY_HALT_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
// Two-digit BCD counter with a fixed range MIN_V..MAX_V.
// Assumes loaded values are legal BCD; anything at or above MAX_V wraps.
module rtc_bcd_wrap
    import rtc_cal_pkg::*;
#(
    parameter bcd_byte_t MIN_V   = 8'h00,
    parameter bcd_byte_t MAX_V   = 8'h99,
    parameter bcd_byte_t LD_MASK = 8'hFF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  bcd_byte_t load_val_i,
    input  logic      inc_i,
    output bcd_byte_t cnt_o,
    output logic      at_max_o
);
    bcd_byte_t cnt_q;

    // Field is at its limit, so the next advance wraps it and carries.
    assign at_max_o = (cnt_q >= MAX_V);
    assign cnt_o    = cnt_q;

    // Load first, otherwise advance or wrap on an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= MIN_V;
        else if (load_i) cnt_q <= load_val_i & LD_MASK;
        else if (inc_i)  cnt_q <= at_max_o ? MIN_V : bcd_next(cnt_q);
    end

    // R2
    wrap_to_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && cnt_q == MAX_V) |=> (cnt_o == MIN_V));
    // R2
    step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && cnt_q < MAX_V) |=> (cnt_o != $past(cnt_o)));
endmodule

// File: rtl/rtc_hour_cnt.sv
// Hours register with run-time 12/24-hour mode kept in its own bit 7.
// at_max_o flags the hour from which the next advance starts a new day.
module rtc_hour_cnt
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  bcd_byte_t load_val_i,
    input  logic      inc_i,
    output bcd_byte_t hour_o,
    output logic      at_max_o
);
    bcd_byte_t hr_q, hr_nxt, h12, h12n, h24, h24n;
    logic      mode12, pm, pm_nxt;

    assign mode12 = hr_q[HR_MODE_BIT];
    assign pm     = hr_q[HR_PM_BIT];
    assign h12    = {3'b000, hr_q[4:0]};
    assign h24    = {2'b00, hr_q[5:0]};
    assign hour_o = hr_q;

    // Day boundary: 11 PM in 12-hour mode, 23 in 24-hour mode.
    assign at_max_o = mode12 ? (pm && h12 == 8'h11) : (h24 >= 8'h23);

    // Next hour value for either mode, with the PM flag toggle.
    always_comb begin
        pm_nxt = pm;
        if (h12 == 8'h12) begin
            h12n = 8'h01;
        end else if (h12 == 8'h11) begin
            h12n   = 8'h12;
            pm_nxt = ~pm;
        end else begin
            h12n = bcd_next(h12);
        end
        h24n = (h24 >= 8'h23) ? 8'h00 : bcd_next(h24);
        if (mode12) hr_nxt = (h12n & 8'h1F) | {1'b1, 1'b0, pm_nxt, 5'b00000};
        else        hr_nxt = h24n & 8'h3F;
    end

    // Load first, otherwise take the next hour on an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      hr_q <= 8'h00;
        else if (load_i) hr_q <= load_val_i & field_mask(REG_HOUR);
        else if (inc_i)  hr_q <= hr_nxt;
    end

    // R6
    pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && mode12 && hr_q[4:0] == 5'h11)
        |=> (hour_o[HR_PM_BIT] != $past(hour_o[HR_PM_BIT]) && hour_o[4:0] == 5'h12));
    // R6
    twelve_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && mode12 && hr_q[4:0] == 5'h12)
        |=> (hour_o[4:0] == 5'h01 && $stable(hour_o[HR_PM_BIT])));
    // R5
    midnight24_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && !mode12 && hr_q[5:0] == 6'h23) |=> (hour_o == 8'h00));
endmodule

// File: rtl/rtc_date_cnt.sv
// Date of month with a limit taken from the month and the year.
// Assumes a leap year whenever the two-digit year is a multiple of four.
module rtc_date_cnt
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  bcd_byte_t load_val_i,
    input  logic      inc_i,
    input  bcd_byte_t month_i,
    input  bcd_byte_t year_i,
    output bcd_byte_t date_o,
    output logic      at_max_o
);
    bcd_byte_t date_q, last_day;
    logic [4:0] mod4_sum;
    logic       leap;

    // Ten is 2 mod 4, so the year mod 4 equals (2*tens + ones) mod 4.
    assign mod4_sum = {year_i[7:4], 1'b0} + {1'b0, year_i[3:0]};
    assign leap     = (mod4_sum[1:0] == 2'b00);

    // Last legal date of the current month.
    always_comb begin
        case (month_i)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

    assign at_max_o = (date_q >= last_day);
    assign date_o   = date_q;

    // Load first, otherwise advance or wrap to the first of the month.
    always_ff @(posedge clk) begin
        if (!rst_n)      date_q <= 8'h01;
        else if (load_i) date_q <= load_val_i & field_mask(REG_DATE);
        else if (inc_i)  date_q <= at_max_o ? 8'h01 : bcd_next(date_q);
    end

    // R8
    feb_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && month_i == 8'h02 && date_q == 8'h28 && !leap)
        |=> (date_o == 8'h01));
    // R7
    month_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !load_i && date_q == 8'h31) |=> (date_o == 8'h01));
endmodule

// File: rtl/rtc_bcd_calendar.sv
// BCD time-of-day and calendar counter advanced by a hundredths tick.
// Carries are computed from the at-limit state of all lower fields, so
// the full ripple lands in one cycle. A load overrides any tick.
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en_i,
    input  logic              load_en_i,
    input  logic [SNAP_W-1:0] load_data_i,
    output logic [SNAP_W-1:0] snapshot_o
);
    localparam logic [SNAP_W-1:0] FULL_MASK = bus_mask();

    bcd_byte_t           fld [NUM_REGS];
    logic [NUM_REGS-1:0] inc_v, at_max_v;
    logic                halt_q, step;

    // Halt bit stored beside the day-of-week digit.
    always_ff @(posedge clk) begin
        if (!rst_n)         halt_q <= 1'b0;
        else if (load_en_i) halt_q <= load_data_i[REG_DOW*BYTE_W + DAY_HALT_BIT];
    end

    assign step = tick_en_i & ~halt_q;

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_field
        // Field advances when stepping and every field below it is at its limit.
        assign inc_v[gi] = step & ((at_max_v & carry_deps(gi)) == carry_deps(gi));

        if (gi == REG_HOUR) begin : g_hour
            rtc_hour_cnt u_hour (
                .clk(clk), .rst_n(rst_n), .load_i(load_en_i),
                .load_val_i(load_data_i[gi*BYTE_W +: BYTE_W]), .inc_i(inc_v[gi]),
                .hour_o(fld[gi]), .at_max_o(at_max_v[gi]));
        end else if (gi == REG_DATE) begin : g_date
            rtc_date_cnt u_date (
                .clk(clk), .rst_n(rst_n), .load_i(load_en_i),
                .load_val_i(load_data_i[gi*BYTE_W +: BYTE_W]), .inc_i(inc_v[gi]),
                .month_i(fld[REG_MON]), .year_i(fld[REG_YEAR]),
                .date_o(fld[gi]), .at_max_o(at_max_v[gi]));
        end else begin : g_simple
            rtc_bcd_wrap #(
                .MIN_V(field_min(gi)), .MAX_V(field_max(gi)), .LD_MASK(field_mask(gi))
            ) u_cnt (
                .clk(clk), .rst_n(rst_n), .load_i(load_en_i),
                .load_val_i(load_data_i[gi*BYTE_W +: BYTE_W]), .inc_i(inc_v[gi]),
                .cnt_o(fld[gi]), .at_max_o(at_max_v[gi]));
        end

        // Snapshot byte, with the halt bit merged into the day register.
        if (gi == REG_DOW) begin : g_snap_dow
            assign snapshot_o[gi*BYTE_W +: BYTE_W] = fld[gi] | (bcd_byte_t'(halt_q) << DAY_HALT_BIT);
        end else begin : g_snap
            assign snapshot_o[gi*BYTE_W +: BYTE_W] = fld[gi];
        end
    end

    // R3
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_q && !load_en_i) |=> $stable(snapshot_o));
    // R4
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_i |=> (snapshot_o == ($past(load_data_i) & FULL_MASK)));
    // R9
    dow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_v[REG_DOW] && at_max_v[REG_DOW] && !load_en_i) |=> (fld[REG_DOW] == 8'h01));
    // R10
    year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_v[REG_YEAR] && at_max_v[REG_YEAR] && !load_en_i)
        |=> (fld[REG_YEAR] == 8'h00 && fld[REG_MON] == 8'h01));
endmodule

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en_i = 1'b0;
    logic        load_en_i = 1'b0;
    logic [63:0] load_data_i = '0;
    logic [63:0] snapshot_o;
    logic [63:0] exp_s;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [63:0] KEEP = 64'hFF1F3F27BF7F7FFF;

    always #10 clk = ~clk;

    rtc_bcd_calendar i_rtc_bcd_calendar (.*);

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction
    function automatic logic [7:0] i2b(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction
    function automatic logic [63:0] mk(input logic [7:0] yr, mo, dt, dw, hr, mi, se, hu);
        return {yr, mo, dt, dw, hr, mi, se, hu};
    endfunction

    // Reference: one hundredth later, worked out in plain integers.
    function automatic logic [63:0] adv(input logic [63:0] s);
        int hu, se, mi, h, dw, dt, mo, yr, last;
        logic m12, pm, dayc;
        logic [7:0] hb, hrb;
        hu = b2i(s[7:0]); se = b2i(s[15:8]); mi = b2i(s[23:16]);
        dw = int'(s[34:32]); dt = b2i(s[47:40]); mo = b2i(s[55:48]); yr = b2i(s[63:56]);
        m12 = s[31]; pm = s[29]; dayc = 0;
        h = m12 ? b2i({3'b0, s[28:24]}) : b2i({2'b0, s[29:24]});
        hu++;
        if (hu == 100) begin
            hu = 0; se++;
            if (se == 60) begin
                se = 0; mi++;
                if (mi == 60) begin
                    mi = 0;
                    if (m12) begin
                        if (h == 12) h = 1;
                        else if (h == 11) begin h = 12; pm = ~pm; dayc = ~pm; end
                        else h++;
                    end else begin
                        h++;
                        if (h == 24) begin h = 0; dayc = 1; end
                    end
                end
            end
        end
        if (dayc) begin
            dw = (dw == 7) ? 1 : dw + 1;
            dt++;
            if (mo == 2) last = (yr % 4 == 0) ? 29 : 28;
            else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) last = 30;
            else last = 31;
            if (dt > last) begin
                dt = 1; mo++;
                if (mo > 12) begin mo = 1; yr = (yr + 1) % 100; end
            end
        end
        hb = i2b(h);
        hrb = m12 ? {1'b1, 1'b0, pm, hb[4:0]} : {2'b00, hb[5:0]};
        return {i2b(yr), i2b(mo), i2b(dt), {2'b00, s[37], 2'b00, 3'(dw)},
                hrb, i2b(mi), i2b(se), i2b(hu)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, predict, sample at the next falling edge.
    task automatic cyc(input string tag, input logic tk, input logic ld, input logic [63:0] d);
        tick_en_i = tk; load_en_i = ld; load_data_i = d;
        if (ld) exp_s = d & KEEP;
        else if (tk && !exp_s[37]) exp_s = adv(exp_s);
        @(negedge clk);
        check(tag, snapshot_o, exp_s);
    endtask

    // Load a time, then apply one tick.
    task automatic edge_case(input string tag, input logic [63:0] t);
        cyc(tag, 1'b0, 1'b1, t);
        cyc(tag, 1'b1, 1'b0, '0);
    endtask

    function automatic logic [63:0] rand_time();
        int mo, yr, dt, last, h;
        logic m12;
        logic [7:0] hrb, hb;
        mo = 1 + $urandom_range(11); yr = $urandom_range(99);
        if (mo == 2) last = (yr % 4 == 0) ? 29 : 28;
        else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) last = 30;
        else last = 31;
        dt = ($urandom_range(3) == 0) ? last : 1 + $urandom_range(last - 1);
        m12 = $urandom_range(1);
        if (m12) begin
            h = ($urandom_range(2) == 0) ? 11 : 1 + $urandom_range(11);
            hb = i2b(h); hrb = {1'b1, 1'b0, 1'($urandom_range(1)), hb[4:0]};
        end else begin
            h = ($urandom_range(2) == 0) ? 23 : $urandom_range(23);
            hb = i2b(h); hrb = {2'b00, hb[5:0]};
        end
        return mk(i2b(yr), i2b(mo), i2b(dt), 8'(1 + $urandom_range(6)), hrb,
                  ($urandom_range(1) != 0) ? 8'h59 : i2b($urandom_range(59)),
                  ($urandom_range(1) != 0) ? 8'h59 : i2b($urandom_range(59)),
                  i2b(90 + $urandom_range(9)));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_s = 64'h0001010100000000;
        @(negedge clk);
        check("R1", snapshot_o, 64'h0001010100000000);

        // R11 byte placement
        cyc("R11", 1'b0, 1'b1, mk(8'h24, 8'h07, 8'h15, 8'h03, 8'h13, 8'h45, 8'h30, 8'h12));
        check("R11", snapshot_o, 64'h2407150313453012);
        // R2 full ripple across midnight
        edge_case("R2", mk(8'h05, 8'h03, 8'h10, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R2", snapshot_o, mk(8'h05, 8'h03, 8'h11, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00));
        // R5 tens-of-hours carry in 24-hour mode
        edge_case("R5", mk(8'h05, 8'h03, 8'h10, 8'h03, 8'h19, 8'h59, 8'h59, 8'h99));
        check("R5", snapshot_o[31:24], 8'h20);
        // R6 12-hour sequence
        edge_case("R6", mk(8'h05, 8'h03, 8'h10, 8'h03, 8'h91, 8'h59, 8'h59, 8'h99));
        check("R6", snapshot_o, mk(8'h05, 8'h03, 8'h10, 8'h03, 8'hB2, 8'h00, 8'h00, 8'h00));
        edge_case("R6", mk(8'h05, 8'h03, 8'h10, 8'h03, 8'hB2, 8'h59, 8'h59, 8'h99));
        check("R6", snapshot_o[31:24], 8'hA1);
        edge_case("R6", mk(8'h05, 8'h03, 8'h10, 8'h03, 8'hB1, 8'h59, 8'h59, 8'h99));
        check("R6", snapshot_o, mk(8'h05, 8'h03, 8'h11, 8'h04, 8'h92, 8'h00, 8'h00, 8'h00));
        // R7 month lengths
        edge_case("R7", mk(8'h05, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R7", snapshot_o[55:40], 16'h0501);
        edge_case("R7", mk(8'h05, 8'h01, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R7", snapshot_o[55:40], 16'h0131);
        // R8 February
        edge_case("R8", mk(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R8", snapshot_o[55:40], 16'h0301);
        edge_case("R8", mk(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R8", snapshot_o[55:40], 16'h0229);
        edge_case("R8", mk(8'h00, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R8", snapshot_o[55:40], 16'h0301);
        // R9 day of week wraps with the date
        edge_case("R9", mk(8'h05, 8'h06, 8'h14, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R9", snapshot_o[47:32], 16'h1501);
        // R10 year end
        edge_case("R10", mk(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h99));
        check("R10", snapshot_o, mk(8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00));
        // R3 halted clock ignores ticks
        cyc("R3", 1'b0, 1'b1, mk(8'h05, 8'h03, 8'h10, 8'h23, 8'h23, 8'h59, 8'h59, 8'h99));
        for (int k = 0; k < 5; k++) cyc("R3", 1'b1, 1'b0, '0);
        check("R3", snapshot_o, mk(8'h05, 8'h03, 8'h10, 8'h23, 8'h23, 8'h59, 8'h59, 8'h99));
        // R4 load beats a tick; zero bits mask off
        cyc("R4", 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF);
        check("R4", snapshot_o, KEEP);
        cyc("R4", 1'b1, 1'b1, mk(8'h05, 8'h03, 8'h10, 8'h03, 8'h12, 8'h00, 8'h00, 8'h50));
        check("R4", snapshot_o, mk(8'h05, 8'h03, 8'h10, 8'h03, 8'h12, 8'h00, 8'h00, 8'h50));

        // R2 random mix of loads, ticks and simultaneous load+tick
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(24) == 0) cyc("R2", 1'($urandom_range(1)), 1'b1, rand_time());
            else cyc("R2", ($urandom_range(9) < 8), 1'b0, '0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule